// File: doc/BRIEF.md
# Data-Bit Steered Dual Panel Router

The router takes one parallel RGB stream, with pixel clock, line sync, frame sync, data enable and a 24-bit colour word, and shares it between two panels that each accept 16-bit RGB565 pixels. The panel choice is made pixel by pixel. It is not taken from line or pixel counters. Instead it is taken from one bus line that the 16-bit panels never use. Software paints a 1-bit select plane into that colour channel of the framebuffer, and that plane sets any split layout: top/bottom, left/right or interleaved.

Each pixel is cut down to RGB565 by keeping the upper 5 red, 6 green and 5 blue bits. The pixel then goes to the panel that its select bit names. The other panel sees its data enable low for that pixel, and its data lines keep their last value. Line and frame sync go to both panels. Every output passes through exactly one register, so data, enable and sync stay aligned.

Top module: `pixel_router`

## Requirements
- R1: While `rst` is high at a clock edge, every output is 0 after that edge.
- R2: A pixel with `de_in`=1 and select bit 0 makes `pnl1_de`=1 and `pnl2_de`=0 one clock later.
- R3: A pixel with `de_in`=1 and select bit 1 makes `pnl2_de`=1 and `pnl1_de`=0 one clock later.
- R4: The selected panel's data, one clock later, is {pix_in[23:19], pix_in[15:10], pix_in[7:3]} (red in bits 15:11, green in 10:5, blue in 4:0).
- R5: A panel that does not take the current pixel keeps its data output unchanged.
- R6: With `de_in`=0, both panel enables are 0 one clock later and neither panel's data changes, whatever the select bit is.
- R7: `hsync_in` and `vsync_in` appear unchanged on both panels' sync outputs one clock later.
- R8: The select bit position is the parameter `SEL_BIT` (default 0). It must be one of the bits that RGB565 drops: 0–2, 8–9 or 16–18. With `SEL_BIT`=16, steering follows pix_in[16] and ignores pix_in[0].
- R9: The two panel enables are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_in | input | 1 | Line sync from the source |
| vsync_in | input | 1 | Frame sync from the source |
| de_in | input | 1 | Data enable from the source |
| pix_in | input | 24 | RGB888 pixel, with the select in bit SEL_BIT |
| pnl1_pix | output | 16 | RGB565 data to panel 1 |
| pnl1_de | output | 1 | Data enable to panel 1 |
| pnl1_hs | output | 1 | Line sync to panel 1 |
| pnl1_vs | output | 1 | Frame sync to panel 1 |
| pnl2_pix | output | 16 | RGB565 data to panel 2 |
| pnl2_de | output | 1 | Data enable to panel 2 |
| pnl2_hs | output | 1 | Line sync to panel 2 |
| pnl2_vs | output | 1 | Frame sync to panel 2 |

## Verification
The assertions take it that all inputs change only between clock edges and carry known values once reset is released. They also take it that `SEL_BIT` names a bit that the colour packing drops, so the select and the colour bits never overlap. The stimulus drives inputs on the falling edge from fully random words and places the select bits of both bench instances (bit 0 and bit 16) on purpose. This covers alternating, run-length and enable-low patterns, as well as a reset in the middle of the stream.

// File: rtl/prt_pkg.sv
package prt_pkg;

    localparam int BUS_W      = 24;
    localparam int RED_W      = 5;
    localparam int GRN_W      = 6;
    localparam int BLU_W      = 5;
    localparam int COL_W      = RED_W + GRN_W + BLU_W;
    localparam int NUM_PANELS = 2;

    typedef struct packed {
        logic [RED_W-1:0] r;
        logic [GRN_W-1:0] g;
        logic [BLU_W-1:0] b;
    } rgb565_t;

    // Keep the most significant bits of each 8-bit colour byte.
    function automatic rgb565_t pack565(input logic [BUS_W-1:0] d);
        rgb565_t c;
        c.r = d[23 -: RED_W];
        c.g = d[15 -: GRN_W];
        c.b = d[7  -: BLU_W];
        return c;
    endfunction

    // True for bus lines that the RGB565 packing throws away.
    function automatic bit is_spare(input int idx);
        return (idx >= 0  && idx <= 7  - BLU_W) ||
               (idx >= 8  && idx <= 15 - GRN_W) ||
               (idx >= 16 && idx <= 23 - RED_W);
    endfunction

endpackage

// File: rtl/beat_split.sv
module beat_split #(
    parameter int SEL_BIT = 0
) (
    input  logic [prt_pkg::BUS_W-1:0] pix_i,
    output logic                      sel_o,
    output prt_pkg::rgb565_t          col_o
);
    always_comb begin
        sel_o = pix_i[SEL_BIT];
        col_o = prt_pkg::pack565(pix_i);
    end
endmodule

// File: rtl/sync_stage.sv
module sync_stage (
    input  logic clk,
    input  logic rst,
    input  logic hs_i,
    input  logic vs_i,
    output logic hs_o,
    output logic vs_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hs_o <= 1'b0;
            vs_o <= 1'b0;
        end else begin
            hs_o <= hs_i;
            vs_o <= vs_i;
        end
    end
endmodule

// File: rtl/panel_lane.sv
module panel_lane #(
    parameter int LANE = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             de_i,
    input  logic             sel_i,
    input  prt_pkg::rgb565_t col_i,
    output logic             de_o,
    output prt_pkg::rgb565_t pix_o
);
    localparam logic MY_SEL = LANE[0];

    logic take;
    always_comb take = de_i && (sel_i == MY_SEL);

    always_ff @(posedge clk) begin
        if (rst) begin
            de_o  <= 1'b0;
            pix_o <= '0;
        end else begin
            de_o <= take;
            if (take) pix_o <= col_i;
        end
    end

    // R2 / R3: enable follows the lane's own take one cycle later
    p_de_on_r2: assert property (@(posedge clk) disable iff (rst)
        take |=> de_o);
    // R6: no take, no enable
    p_de_off_r6: assert property (@(posedge clk) disable iff (rst)
        !take |=> !de_o);
    // R4: loaded colour is the packed input of the previous cycle
    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        take |=> (pix_o == $past(col_i)));
    // R5: data holds while the lane is not taking
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(pix_o));
endmodule

// File: rtl/pixel_router.sv
module pixel_router #(
    parameter int SEL_BIT = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hsync_in,
    input  logic        vsync_in,
    input  logic        de_in,
    input  logic [23:0] pix_in,
    output logic [15:0] pnl1_pix,
    output logic        pnl1_de,
    output logic        pnl1_hs,
    output logic        pnl1_vs,
    output logic [15:0] pnl2_pix,
    output logic        pnl2_de,
    output logic        pnl2_hs,
    output logic        pnl2_vs
);
    localparam int NP = prt_pkg::NUM_PANELS;

    logic             sel;
    prt_pkg::rgb565_t col;
    logic             hs_q, vs_q;
    logic [NP-1:0]    de_q;
    prt_pkg::rgb565_t pix_q [NP];

    beat_split #(.SEL_BIT(SEL_BIT)) u_split (
        .pix_i (pix_in),
        .sel_o (sel),
        .col_o (col)
    );

    sync_stage u_sync (
        .clk  (clk),
        .rst  (rst),
        .hs_i (hsync_in),
        .vs_i (vsync_in),
        .hs_o (hs_q),
        .vs_o (vs_q)
    );

    generate
        for (genvar gi = 0; gi < NP; gi++) begin : g_lane
            panel_lane #(.LANE(gi)) u_lane (
                .clk   (clk),
                .rst   (rst),
                .de_i  (de_in),
                .sel_i (sel),
                .col_i (col),
                .de_o  (de_q[gi]),
                .pix_o (pix_q[gi])
            );
        end
    endgenerate

    always_comb begin
        pnl1_pix = pix_q[0];
        pnl1_de  = de_q[0];
        pnl1_hs  = hs_q;
        pnl1_vs  = vs_q;
        pnl2_pix = pix_q[1];
        pnl2_de  = de_q[1];
        pnl2_hs  = hs_q;
        pnl2_vs  = vs_q;
    end

    // R9: panels never enabled together
    p_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(pnl1_de && pnl2_de));
    // R7: syncs reach both panels one cycle later
    p_sync_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pnl1_hs == $past(hsync_in)) && (pnl2_hs == $past(hsync_in)) &&
                 (pnl1_vs == $past(vsync_in)) && (pnl2_vs == $past(vsync_in)));
    // R2 / R3: steering by the select bit
    p_steer_r3: assert property (@(posedge clk) disable iff (rst)
        (de_in && pix_in[SEL_BIT]) |=> (pnl2_de && !pnl1_de));
    // R1: reset clears the outputs
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!pnl1_de && !pnl2_de && pnl1_pix == 16'h0 && pnl2_pix == 16'h0));
endmodule

// File: tb/sim_pixel_router.sv
module sim_pixel_router;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hs = 1'b0, vs = 1'b0, de = 1'b0;
    logic [23:0] pix = '0;

    logic [15:0] o_pix [2][2];
    logic        o_de  [2][2];
    logic        o_hs  [2][2];
    logic        o_vs  [2][2];

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pixel_router #(.SEL_BIT(0)) u0 (
        .clk(clk), .rst(rst), .hsync_in(hs), .vsync_in(vs), .de_in(de), .pix_in(pix),
        .pnl1_pix(o_pix[0][0]), .pnl1_de(o_de[0][0]), .pnl1_hs(o_hs[0][0]), .pnl1_vs(o_vs[0][0]),
        .pnl2_pix(o_pix[0][1]), .pnl2_de(o_de[0][1]), .pnl2_hs(o_hs[0][1]), .pnl2_vs(o_vs[0][1]));

    // R8: second instance steered from bit 16
    pixel_router #(.SEL_BIT(16)) u1 (
        .clk(clk), .rst(rst), .hsync_in(hs), .vsync_in(vs), .de_in(de), .pix_in(pix),
        .pnl1_pix(o_pix[1][0]), .pnl1_de(o_de[1][0]), .pnl1_hs(o_hs[1][0]), .pnl1_vs(o_vs[1][0]),
        .pnl2_pix(o_pix[1][1]), .pnl2_de(o_de[1][1]), .pnl2_hs(o_hs[1][1]), .pnl2_vs(o_vs[1][1]));

    // Behavioural reference model
    int  e_pix [2][2];
    bit  e_de  [2][2];
    bit  e_hs, e_vs, m_rst, m_de, m_valid = 0;
    int  m_sel [2];

    function automatic int to565(input int d);
        int r, g, b;
        r = ((d >> 16) & 255) / 8;
        g = ((d >> 8) & 255) / 4;
        b = (d & 255) / 8;
        return r * 2048 + g * 32 + b;
    endfunction

    always @(posedge clk) begin
        m_rst = rst;
        m_de  = de;
        if (rst) begin
            e_hs = 0; e_vs = 0;
            for (int i = 0; i < 2; i++)
                for (int p = 0; p < 2; p++) begin e_pix[i][p] = 0; e_de[i][p] = 0; end
        end else begin
            e_hs = hs; e_vs = vs;
            for (int i = 0; i < 2; i++) begin
                m_sel[i] = (i == 0) ? int'(pix[0]) : int'(pix[16]);
                for (int p = 0; p < 2; p++) begin
                    if (de && m_sel[i] == p) begin
                        e_de[i][p]  = 1;
                        e_pix[i][p] = to565(int'(pix));
                    end else begin
                        e_de[i][p] = 0;
                    end
                end
            end
        end
        m_valid = 1;
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        string tg;
        if (!m_valid) return;
        for (int i = 0; i < 2; i++) begin
            for (int p = 0; p < 2; p++) begin
                if (m_rst) tg = "R1";
                else if (i == 1) tg = "R8";
                else if (!m_de) tg = "R6";
                else if (p == 0) tg = "R2";
                else tg = "R3";
                chk(o_de[i][p] == e_de[i][p], tg, $sformatf("u%0d panel%0d de", i, p+1),
                    int'(o_de[i][p]), int'(e_de[i][p]));
                if (m_rst) tg = "R1";
                else if (i == 1) tg = "R8";
                else if (m_de && m_sel[i] == p) tg = "R4";
                else tg = "R5";
                chk(int'(o_pix[i][p]) == e_pix[i][p], tg, $sformatf("u%0d panel%0d pix", i, p+1),
                    int'(o_pix[i][p]), e_pix[i][p]);
                tg = m_rst ? "R1" : "R7";
                chk(o_hs[i][p] == e_hs && o_vs[i][p] == e_vs, tg, $sformatf("u%0d panel%0d syncs", i, p+1),
                    int'({o_hs[i][p], o_vs[i][p]}), int'({e_hs, e_vs}));
            end
            chk(!(o_de[i][0] && o_de[i][1]), "R9", $sformatf("u%0d both enables", i),
                int'({o_de[i][0], o_de[i][1]}), 1);
        end
    endtask

    task automatic step(input bit r, input bit d, input bit h, input bit v, input logic [23:0] px);
        @(negedge clk);
        check_all();
        rst = r; de = d; hs = h; vs = v; pix = px;
    endtask

    function automatic logic [23:0] mkpix(input bit s0, input bit s16);
        logic [23:0] w;
        w = 24'($urandom);
        w[0] = s0;
        w[16] = s16;
        return w;
    endfunction

    initial begin
        // reset phase (R1)
        for (int k = 0; k < 4; k++) step(1, 1, 1, 1, 24'($urandom));
        // alternating select every pixel, with line sync pulses (R2, R3, R4, R5, R7)
        for (int k = 0; k < 200; k++)
            step(0, 1, (k % 40) < 4, k < 10, mkpix(k[0], ~k[0]));
        // runs of the same select (R5 hold on the idle panel)
        for (int k = 0; k < 300; k++)
            step(0, 1, (k % 50) < 3, 0, mkpix((k / 37) % 2 == 1, (k / 23) % 2 == 1));
        // enable low, random data and selects (R6)
        for (int k = 0; k < 80; k++)
            step(0, 0, k[2], k[4], 24'($urandom));
        // fully random traffic
        for (int k = 0; k < 2000; k++)
            step(0, ($urandom % 4) != 0, 1'($urandom), 1'($urandom), 24'($urandom));
        // reset in the middle of the stream (R1)
        for (int k = 0; k < 3; k++) step(1, 1, 1, 0, 24'($urandom));
        for (int k = 0; k < 300; k++)
            step(0, ($urandom % 3) != 0, 1'($urandom), 1'($urandom), 24'($urandom));
        @(negedge clk);
        check_all();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule